// File: doc/BRIEF.md
# Two-Channel Timer Word DMA Sequencer with Ping-Pong Pointer Banks

This block moves 16-bit timer words between a timer and an 8-bit register file over two DMA channels. Channel 0 serves the compare unit: it reads two bytes from the register file and hands the assembled word to the timer. Channel 1 serves the capture unit: it samples the timer's captured word and writes it to the register file as two bytes. Each word travels as two byte transfers on consecutive cycles, low byte first. During the second byte the block drives the top bus priority (000), whatever level the channel was programmed with. Once a word has started, no request from the other channel can break into it.

Each channel has a byte address pointer and a word counter. Both live in a small pointer file of eight byte entries, addressed as {bank, channel, field}: index bit 2 selects the bank, bit 1 selects the channel (0 compare, 1 capture), and bit 0 selects the field (0 counter, 1 address pointer). The bank a channel uses is given by that channel's own toggle bit. When a counter reaches zero, the block pulses the channel's end-of-block line. If swap mode is on, the same event flips that channel's toggle bit, so the next block runs from the alternate pair. Software can then refill the pair that has just finished.

The controller has three states: `ST_IDLE` waits and arbitrates, `ST_LO` drives the low byte, `ST_HI` drives the high byte. The transitions are IDLE to LO on a grant, LO to HI always, and HI to IDLE always. A new word therefore starts no sooner than one cycle after the previous one ends.

Top module: `tmr_dma_seq`

## Requirements
- R1: A granted word occupies exactly two consecutive bus cycles (`bus_vld` high). The first byte goes to the channel's address pointer A and the second to A+1. After the word the stored pointer reads A+2, and `bus_vld` is low in the following cycle.
- R2: The first byte carries the channel's programmed priority on `bus_prio`. The second byte carries 000.
- R3: A request from the other channel that arrives while a word is in progress does not split the word. It is served by a separate word once the current word has finished.
- R4: When both channels are eligible, the lower `prio` value wins. On equal values the compare channel (`bus_chan`=0) wins.
- R5: A request pulse is latched and stays pending until it is granted. A request for a channel whose active counter is zero is served once software loads a nonzero count.
- R6: Each word decrements the channel's active counter. When the counter reaches zero, `eob` bit c (bit 0 compare, bit 1 capture) is high for exactly one cycle, the cycle after the second byte.
- R7: With `swap_en` low, a channel whose counter has reached zero starts no transfer, even when requested.
- R8: With `swap_en` high, end of block flips only that channel's bit of `tog` (bit 0 compare, bit 1 capture). The channel's next word uses the pointer pair whose index has bit 2 equal to the new toggle value.
- R9: The pointer file is written through `sw_we`/`sw_idx`/`sw_wdata` and read combinationally on `sw_rdata`, using the {bank, channel, field} index layout. `tog_we` loads `tog` from `tog_wdata`.
- R10: A compare word reads `bus_rdata` in both byte cycles (`bus_wr`=0). In the cycle after the second byte it presents {high, low} on `cmp_word` with `cmp_load` high. A capture word (`bus_wr`=1) writes `cap_word` as sampled at grant, low byte first.
- R11: After reset: no bus activity, `eob`=0, `cmp_load`=0, `tog`=0, and the pointer file reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 2 | Request pulses, bit 0 compare, bit 1 capture |
| prio_cmp | input | 3 | Programmed priority of the compare channel (0 highest) |
| prio_cap | input | 3 | Programmed priority of the capture channel (0 highest) |
| swap_en | input | 1 | Ping-pong swap enable, shared by both channels |
| cap_word | input | 16 | Timer capture word, sampled at grant |
| sw_we | input | 1 | Pointer file write strobe |
| sw_idx | input | 3 | Pointer file index {bank, channel, field} |
| sw_wdata | input | 8 | Pointer file write data |
| sw_rdata | output | 8 | Pointer file read data at `sw_idx` |
| tog_we | input | 1 | Toggle bit write strobe |
| tog_wdata | input | 2 | Toggle bit write data |
| tog | output | 2 | Bank toggle bits, bit 0 compare, bit 1 capture |
| bus_vld | output | 1 | Byte transfer in this cycle |
| bus_chan | output | 1 | Channel owning the transfer |
| bus_wr | output | 1 | 1 = write to register file, 0 = read |
| bus_addr | output | 8 | Register file byte address |
| bus_prio | output | 3 | Bus priority of this byte |
| bus_wdata | output | 8 | Write data (capture channel) |
| bus_rdata | input | 8 | Read data from register file, same cycle |
| cmp_word | output | 16 | Assembled compare word |
| cmp_load | output | 1 | One-cycle strobe, `cmp_word` valid |
| eob | output | 2 | One-cycle end-of-block pulses per channel |

## Verification
The assertions assume that `prio_cmp` and `prio_cap` stay constant while a word is on the bus. They also assume that software writes neither the pointer file nor the toggle bits during a word, since such a write could move `bus_addr` between the two bytes. The stimulus changes priorities and writes pointers only while the sequencer is idle. It waits out the full word, including the trailing idle cycle, before reprogramming anything.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2
    } tdma_st_t;

    localparam int TDMA_NCH = 2;
endpackage

// File: rtl/tdma_ptr_file.sv
module tdma_ptr_file #(
    parameter int DW = 8,
    parameter int NE = 8,
    localparam int IW = $clog2(NE)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sw_we,
    input  logic [IW-1:0]          sw_idx,
    input  logic [DW-1:0]          sw_wdata,
    input  logic                   a_we,
    input  logic [IW-1:0]          a_idx,
    input  logic [DW-1:0]          a_val,
    input  logic                   c_we,
    input  logic [IW-1:0]          c_idx,
    input  logic [DW-1:0]          c_val,
    output logic [NE-1:0][DW-1:0]  q
);
    // DMA pointer updates take precedence over software writes to the same entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            for (int i = 0; i < NE; i++) begin
                if (a_we && a_idx == IW'(i))
                    q[i] <= a_val;
                else if (c_we && c_idx == IW'(i))
                    q[i] <= c_val;
                else if (sw_we && sw_idx == IW'(i))
                    q[i] <= sw_wdata;
            end
        end
    end
endmodule

// File: rtl/tdma_arb.sv
module tdma_arb #(
    parameter int PW = 3
) (
    input  logic [1:0]    elig,
    input  logic [PW-1:0] prio_cmp,
    input  logic [PW-1:0] prio_cap,
    output logic          grant,
    output logic          sel
);
    // lower value wins; on a tie the compare channel (0) wins
    always_comb begin
        grant = |elig;
        sel   = elig[1] && (!elig[0] || (prio_cap < prio_cmp));
    end
endmodule

// File: rtl/tmr_dma_seq.sv
module tmr_dma_seq
    import tdma_pkg::*;
#(
    parameter int DW = 8,
    parameter int PW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      req,
    input  logic [PW-1:0]   prio_cmp,
    input  logic [PW-1:0]   prio_cap,
    input  logic            swap_en,
    input  logic [2*DW-1:0] cap_word,
    input  logic            sw_we,
    input  logic [2:0]      sw_idx,
    input  logic [DW-1:0]   sw_wdata,
    output logic [DW-1:0]   sw_rdata,
    input  logic            tog_we,
    input  logic [1:0]      tog_wdata,
    output logic [1:0]      tog,
    output logic            bus_vld,
    output logic            bus_chan,
    output logic            bus_wr,
    output logic [DW-1:0]   bus_addr,
    output logic [PW-1:0]   bus_prio,
    output logic [DW-1:0]   bus_wdata,
    input  logic [DW-1:0]   bus_rdata,
    output logic [2*DW-1:0] cmp_word,
    output logic            cmp_load,
    output logic [1:0]      eob
);
    localparam int WW = 2 * DW;
    localparam int NE = 2 * TDMA_NCH;
    localparam int FE = 2 * NE;
    localparam int IW = $clog2(FE);

    tdma_st_t state, nxt;

    logic [FE-1:0][DW-1:0] file_q;
    logic [1:0]    pend, elig, pend_clr, tog_q;
    logic          grant, sel, start, cur_ch;
    logic [WW-1:0] cap_hold;
    logic [DW-1:0] lo_byte, cur_cnt;
    logic [IW-1:0] cur_aidx, cur_cidx;
    logic          a_we, c_we, last_word;
    logic [DW-1:0] a_val, c_val;

    // a channel is eligible when it has a request and its active counter is nonzero (R5, R7)
    assign elig[0] = (pend[0] | req[0]) && (file_q[{tog_q[0], 2'b00}] != '0);
    assign elig[1] = (pend[1] | req[1]) && (file_q[{tog_q[1], 2'b10}] != '0);

    tdma_arb #(.PW(PW)) u_arb (
        .elig     (elig),
        .prio_cmp (prio_cmp),
        .prio_cap (prio_cap),
        .grant    (grant),
        .sel      (sel)
    );

    assign start     = (state == ST_IDLE) && grant;
    assign pend_clr  = start ? (sel ? 2'b10 : 2'b01) : 2'b00;
    // each channel forms its pointer index from its own toggle bit only (R8)
    assign cur_aidx  = {tog_q[cur_ch], cur_ch, 1'b1};
    assign cur_cidx  = {tog_q[cur_ch], cur_ch, 1'b0};
    assign cur_cnt   = file_q[cur_cidx];
    assign last_word = (cur_cnt == DW'(1));

    assign a_we  = bus_vld;
    assign a_val = bus_addr + DW'(1);
    assign c_we  = (state == ST_HI);
    assign c_val = cur_cnt - DW'(1);

    tdma_ptr_file #(.DW(DW), .NE(FE)) u_file (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_we    (sw_we),
        .sw_idx   (sw_idx),
        .sw_wdata (sw_wdata),
        .a_we     (a_we),
        .a_idx    (cur_aidx),
        .a_val    (a_val),
        .c_we     (c_we),
        .c_idx    (cur_cidx),
        .c_val    (c_val),
        .q        (file_q)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (grant) nxt = ST_LO;
            ST_LO:   nxt = ST_HI;
            ST_HI:   nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // bus outputs per state (R1, R2, R10)
    always_comb begin
        bus_vld   = 1'b0;
        bus_prio  = cur_ch ? prio_cap : prio_cmp;
        bus_wdata = '0;
        unique case (state)
            ST_IDLE: bus_vld = 1'b0;
            ST_LO: begin
                bus_vld   = 1'b1;
                bus_wdata = cur_ch ? cap_hold[DW-1:0] : '0;
            end
            ST_HI: begin
                bus_vld   = 1'b1;
                bus_prio  = '0;
                bus_wdata = cur_ch ? cap_hold[WW-1:DW] : '0;
            end
            default: bus_vld = 1'b0;
        endcase
    end

    assign bus_chan = cur_ch;
    assign bus_wr   = cur_ch;
    assign bus_addr = file_q[cur_aidx];
    assign sw_rdata = file_q[sw_idx];
    assign tog      = tog_q;

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend     <= '0;
            tog_q    <= '0;
            cur_ch   <= 1'b0;
            cap_hold <= '0;
            lo_byte  <= '0;
            cmp_word <= '0;
            cmp_load <= 1'b0;
            eob      <= '0;
        end else begin
            pend     <= (pend | req) & ~pend_clr;
            cmp_load <= 1'b0;
            eob      <= '0;
            if (tog_we) tog_q <= tog_wdata;
            if (start) begin
                cur_ch   <= sel;
                cap_hold <= cap_word;
            end
            if (state == ST_LO) lo_byte <= bus_rdata;
            if (state == ST_HI) begin
                if (!cur_ch) begin
                    cmp_word <= {bus_rdata, lo_byte};
                    cmp_load <= 1'b1;
                end
                if (last_word) begin
                    eob[cur_ch] <= 1'b1;
                    if (swap_en) tog_q[cur_ch] <= ~tog_q[cur_ch];
                end
            end
        end
    end
endmodule

// File: rtl/tmr_dma_seq_chk.sv
module tmr_dma_seq_chk #(
    parameter int DW = 8,
    parameter int PW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [PW-1:0] prio_cmp,
    input logic [PW-1:0] prio_cap,
    input logic          bus_vld,
    input logic          bus_chan,
    input logic [DW-1:0] bus_addr,
    input logic [PW-1:0] bus_prio,
    input logic [1:0]    eob
);
    // R2
    first_byte_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vld && !$past(bus_vld)) |-> (bus_prio == (bus_chan ? prio_cap : prio_cmp)));

    // R2
    second_byte_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vld && $past(bus_vld)) |-> (bus_prio == '0));

    // R3
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vld && !$past(bus_vld)) |=> (bus_vld && $stable(bus_chan)));

    // R1
    byte_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vld && $past(bus_vld)) |-> (bus_addr == DW'($past(bus_addr) + DW'(1))));

    // R1
    word_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vld && $past(bus_vld)) |=> !bus_vld);

    // R6
    eob_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eob));

    // R6
    eob_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eob != 2'b00) |=> (eob == 2'b00));

    // R6
    eob_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eob != 2'b00) |-> ($past(bus_vld) && !bus_vld));
endmodule

bind tmr_dma_seq tmr_dma_seq_chk #(.DW(DW), .PW(PW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .prio_cmp (prio_cmp),
    .prio_cap (prio_cap),
    .bus_vld  (bus_vld),
    .bus_chan (bus_chan),
    .bus_addr (bus_addr),
    .bus_prio (bus_prio),
    .eob      (eob)
);

// File: tb/tmr_dma_seq_test.sv
module tmr_dma_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  req = '0;
    logic [2:0]  prio_cmp = '0, prio_cap = '0;
    logic        swap_en = 1'b0;
    logic [15:0] cap_word = '0;
    logic        sw_we = 1'b0;
    logic [2:0]  sw_idx = '0;
    logic [7:0]  sw_wdata = '0;
    logic [7:0]  sw_rdata;
    logic        tog_we = 1'b0;
    logic [1:0]  tog_wdata = '0;
    logic [1:0]  tog;
    logic        bus_vld, bus_chan, bus_wr;
    logic [7:0]  bus_addr, bus_wdata, bus_rdata;
    logic [2:0]  bus_prio;
    logic [15:0] cmp_word;
    logic        cmp_load;
    logic [1:0]  eob;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    // register file model: contents are a fixed function of the address
    assign bus_rdata = bus_addr ^ 8'hC3;

    tmr_dma_seq uut (
        .clk(clk), .rst_n(rst_n), .req(req), .prio_cmp(prio_cmp), .prio_cap(prio_cap),
        .swap_en(swap_en), .cap_word(cap_word), .sw_we(sw_we), .sw_idx(sw_idx),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .tog_we(tog_we), .tog_wdata(tog_wdata),
        .tog(tog), .bus_vld(bus_vld), .bus_chan(bus_chan), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_prio(bus_prio), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cmp_word(cmp_word), .cmp_load(cmp_load), .eob(eob)
    );

    // fields: req[8:7] prio_cmp[6:4] prio_cap[3:1] expected first channel[0]
    localparam logic [8:0] TBL [6] = '{
        {2'b11, 3'd3, 3'd3, 1'b0},
        {2'b11, 3'd5, 3'd2, 1'b1},
        {2'b11, 3'd1, 3'd6, 1'b0},
        {2'b01, 3'd7, 3'd0, 1'b0},
        {2'b10, 3'd0, 3'd7, 1'b1},
        {2'b11, 3'd6, 3'd6, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic sw_wr(input logic [2:0] idx, input logic [7:0] val);
        sw_we = 1'b1; sw_idx = idx; sw_wdata = val;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic tog_wr(input logic [1:0] val);
        tog_we = 1'b1; tog_wdata = val;
        @(negedge clk);
        tog_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [2:0] idx, input logic [7:0] exp);
        sw_idx = idx;
        #1;
        chk(tag, sw_rdata, exp);
    endtask

    task automatic pulse(input logic [1:0] r);
        req = r;
        @(negedge clk);
        req = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 bus_vld", bus_vld, 0);
        chk("R11 eob", eob, 0);
        chk("R11 cmp_load", cmp_load, 0);
        chk("R11 tog", tog, 0);
        rd("R11 file", 3'd5, 8'h00);

        // table walk: arbitration and priority forcing
        foreach (TBL[k]) begin
            logic ex;
            ex = TBL[k][0];
            sw_wr(3'd0, 8'd4); sw_wr(3'd1, 8'h20);
            sw_wr(3'd2, 8'd4); sw_wr(3'd3, 8'h40);
            prio_cmp = TBL[k][6:4];
            prio_cap = TBL[k][3:1];
            pulse(TBL[k][8:7]);
            chk("R4 first channel", bus_chan, ex);
            chk("R2 first byte prio", bus_prio, ex ? prio_cap : prio_cmp);
            chk("R1 first addr", bus_addr, ex ? 8'h40 : 8'h20);
            @(negedge clk);
            chk("R2 second byte prio", bus_prio, 0);
            chk("R3 same channel", bus_chan, ex);
            @(negedge clk);
            chk("R1 gap after word", bus_vld, 0);
            if (TBL[k][8:7] == 2'b11) begin
                @(negedge clk);
                chk("R4 loser served next", {bus_vld, bus_chan}, {1'b1, ~ex});
                chk("R2 loser prio", bus_prio, ex ? prio_cmp : prio_cap);
                @(negedge clk);
                @(negedge clk);
            end
            @(negedge clk);
        end

        // R1 / R10 compare word
        prio_cmp = 3'd2; prio_cap = 3'd2;
        sw_wr(3'd0, 8'd3); sw_wr(3'd1, 8'h30);
        pulse(2'b01);
        chk("R10 compare reads", bus_wr, 0);
        chk("R1 low addr", bus_addr, 8'h30);
        @(negedge clk);
        chk("R1 high addr", bus_addr, 8'h31);
        @(negedge clk);
        chk("R10 cmp_load", cmp_load, 1);
        chk("R10 cmp_word", cmp_word, 16'hF2F3);
        chk("R6 no eob mid block", eob, 0);
        rd("R1 pointer advanced", 3'd1, 8'h32);
        rd("R6 counter decremented", 3'd0, 8'd2);
        @(negedge clk);

        // R10 capture word, sampled at grant
        sw_wr(3'd2, 8'd3); sw_wr(3'd3, 8'h50);
        cap_word = 16'hBEEF;
        pulse(2'b10);
        cap_word = 16'h0000;
        chk("R10 capture writes", bus_wr, 1);
        chk("R10 low byte", bus_wdata, 8'hEF);
        chk("R1 capture addr", bus_addr, 8'h50);
        @(negedge clk);
        chk("R10 high byte", bus_wdata, 8'hBE);
        @(negedge clk);
        @(negedge clk);

        // R3 request from a higher-priority channel during a word
        prio_cmp = 3'd4; prio_cap = 3'd1;
        sw_wr(3'd0, 8'd3); sw_wr(3'd1, 8'h20);
        sw_wr(3'd2, 8'd3); sw_wr(3'd3, 8'h40);
        req = 2'b01;
        @(negedge clk);
        req = 2'b10;
        chk("R3 compare started", bus_chan, 0);
        @(negedge clk);
        req = 2'b00;
        chk("R3 word not split", {bus_vld, bus_chan, bus_prio}, {1'b1, 1'b0, 3'd0});
        @(negedge clk);
        chk("R3 gap", bus_vld, 0);
        @(negedge clk);
        chk("R3 capture served after", {bus_vld, bus_chan}, 2'b11);
        repeat (3) @(negedge clk);

        // R6 / R7 / R5 end of block without swap
        swap_en = 1'b0;
        sw_wr(3'd0, 8'd1); sw_wr(3'd1, 8'h10);
        pulse(2'b01);
        @(negedge clk);
        @(negedge clk);
        chk("R6 eob compare", eob, 2'b01);
        @(negedge clk);
        chk("R6 eob single cycle", eob, 2'b00);
        rd("R6 counter zero", 3'd0, 8'd0);
        chk("R7 tog unchanged", tog, 0);
        pulse(2'b01);
        for (int i = 0; i < 3; i++) begin
            chk("R7 idle at zero count", bus_vld, 0);
            @(negedge clk);
        end
        sw_wr(3'd0, 8'd1);
        @(negedge clk);
        chk("R5 pending served after reload", {bus_vld, bus_chan}, 2'b10);
        repeat (3) @(negedge clk);

        // R9 toggle write and read back
        tog_wr(2'b01);
        chk("R9 tog written", tog, 2'b01);
        tog_wr(2'b00);

        // R8 swap on capture channel
        swap_en = 1'b1;
        sw_wr(3'd2, 8'd1); sw_wr(3'd3, 8'h40);
        sw_wr(3'd6, 8'd2); sw_wr(3'd7, 8'h80);
        pulse(2'b10);
        chk("R8 bank0 addr", bus_addr, 8'h40);
        @(negedge clk);
        @(negedge clk);
        chk("R8 eob capture", eob, 2'b10);
        chk("R8 capture toggled only", tog, 2'b10);
        @(negedge clk);
        pulse(2'b10);
        chk("R8 alternate pair used", {bus_vld, bus_chan, bus_addr}, {2'b11, 8'h80});
        @(negedge clk);
        @(negedge clk);
        chk("R8 no eob on count 2", eob, 2'b00);
        rd("R9 alternate pointer", 3'd7, 8'h82);
        rd("R9 alternate counter", 3'd6, 8'd1);
        rd("R9 bank0 counter kept", 3'd2, 8'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R11 watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule